// File: doc/BRIEF.md
# Line Drive Start-Up and Protection Controller

This block supervises the horizontal timebase of a display deflection path. It runs on the line-locked timebase clock, which ticks 432 times per line, and divides that clock into line periods. From the line count it produces the horizontal drive pulse. The pulse width starts short and widens by one clock per line, so the output stage comes up gently after each enable.

After power-on the block holds the oscillator trim at a code above nominal, keeps the drive off and raises a power-on status flag. Calibration of the oscillator is sequenced by two register-write strobes. The strobe that loads the crystal indication must arrive first. A later write to the next register then starts calibration. During calibration the trim code moves one step per line until the measured line length equals 432 reference counts. A loss-of-lock report from the coincidence detector starts the calibration again.

The drive is gated off in standby, after an over-voltage trip and after power-on reset. A trip or a power-on reset is cleared only by a restart command. The block also picks the phase-loop time constant from a forced mode, or in automatic mode from lock and noise.

Top module: `line_drive_supervisor`

## Requirements
- R1: A line lasts exactly 432 clock cycles, so rising edges of a free-running drive pulse are 432 cycles apart.
- R2: After rst_n or a por_i pulse, por_flag_o is 1 and hdrv_o is 0 one cycle later, and trim_o holds the power-on code 60, which is above nominal.
- R3: wr_sub1_i starts calibration only if wr_sub0_i has been seen since the last reset or por_i. Without that earlier write, wr_sub1_i leaves trim_o unchanged.
- R4: While calibrating, trim_o changes at each line end. It drops by 1 if line_meas_i > 432, rises by 1 if line_meas_i < 432, and saturates at 0 and 63. Calibration ends when line_meas_i equals 432 at a line end.
- R5: A fall of lock_i (1 then 0 on consecutive cycles) restarts calibration, provided the crystal-indication write has been seen.
- R6: hdrv_o stays 0 while run_en_i is 0, while por_flag_o is 1, or while prot_flag_o is 1.
- R7: prot_trip_i sets prot_flag_o on the next cycle. A restart command (wr_sub1_i with run_en_i = 1) clears both por_flag_o and prot_flag_o. A trip in the same cycle as a restart keeps prot_flag_o at 1.
- R8: When the drive becomes enabled, the first pulse at a line start is 9 cycles wide. Each following pulse is 1 cycle wider, up to 238 cycles, and the width then stays at 238. Any gating returns the width to 9.
- R9: loop_tc_o is registered and uses the codes 0 open, 1 slow, 2 medium, 3 fast. loop_open_i = 1 gives 0. Otherwise loop_mode_i = 1 gives 1, loop_mode_i = 2 gives 3, and loop_mode_i of 0 or 3 (automatic) gives 2 when lock_i = 0 and noisy_i = 0, and 1 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, 432 per line |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on-reset detect pulse |
| prot_trip_i | input | 1 | Over-voltage protection trip |
| lock_i | input | 1 | Coincidence detector: 1 = locked |
| wr_sub0_i | input | 1 | Write strobe, crystal-indication register |
| wr_sub1_i | input | 1 | Write strobe, following register |
| run_en_i | input | 1 | 1 = normal operation, 0 = standby |
| noisy_i | input | 1 | Noise detector flag |
| loop_open_i | input | 1 | Open the phase loop |
| loop_mode_i | input | 2 | 0/3 automatic, 1 forced slow, 2 forced fast |
| line_meas_i | input | 10 | Measured line length in reference counts |
| hdrv_o | output | 1 | Horizontal drive pulse |
| por_flag_o | output | 1 | Power-on status flag |
| prot_flag_o | output | 1 | Protection status flag |
| trim_o | output | 6 | Oscillator frequency-trim code |
| loop_tc_o | output | 2 | Selected phase-loop time constant |

## Verification
A wrong line count shows up as a drive period other than 432 cycles, either in the very next line or within one line of release from reset. A wrong duty register or gating flag changes the pulse width or the pulse presence within the current line. A flag or calibration state that misses a strobe shows either as a status output off by one cycle or as a trim code that moves, or fails to move, at the next line end. A reference model compared on every clock therefore exposes each such fault within one line of its cause.

// File: rtl/lds_pkg.sv
package lds_pkg;
    typedef enum logic [1:0] {
        TC_OPEN = 2'd0,
        TC_SLOW = 2'd1,
        TC_MED  = 2'd2,
        TC_FAST = 2'd3
    } loop_tc_e;

    typedef enum logic [1:0] {
        MODE_AUTO0 = 2'd0,
        MODE_SLOW  = 2'd1,
        MODE_FAST  = 2'd2,
        MODE_AUTO1 = 2'd3
    } loop_mode_e;
endpackage

// File: rtl/lds_line_timer.sv
module lds_line_timer #(
    parameter int LINE_CLKS = 432,
    parameter int CNT_W     = $clog2(LINE_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             line_end_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_CLKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_d_o    = st_d.cnt;
    assign line_end_o = (st_q.cnt == LAST);

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LAST) |=> (st_q.cnt == '0));
    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
endmodule

// File: rtl/lds_osc_cal.sv
module lds_osc_cal #(
    parameter int LINE_CLKS = 432,
    parameter int MEAS_W    = 10,
    parameter int TRIM_W    = 6,
    parameter int TRIM_POR  = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_i,
    input  logic              wr_xtal_i,
    input  logic              wr_cal_i,
    input  logic              lock_i,
    input  logic              line_end_i,
    input  logic [MEAS_W-1:0] line_meas_i,
    output logic [TRIM_W-1:0] trim_o
);
    localparam logic [MEAS_W-1:0] MEAS_NOM = MEAS_W'(LINE_CLKS);
    localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(TRIM_POR);

    typedef struct packed {
        logic              xtal_seen;
        logic              cal_on;
        logic              lock_prev;
        logic [TRIM_W-1:0] trim;
    } cal_st_t;

    cal_st_t st_q, st_d;
    logic    cal_start;

    always_comb begin
        st_d           = st_q;
        cal_start      = 1'b0;
        st_d.lock_prev = lock_i;
        if (por_i) begin
            st_d.xtal_seen = 1'b0;
            st_d.cal_on    = 1'b0;
            st_d.trim      = TRIM_RST;
        end else begin
            st_d.xtal_seen = st_q.xtal_seen | wr_xtal_i;
            if (st_q.cal_on && line_end_i) begin
                if (line_meas_i == MEAS_NOM) begin
                    st_d.cal_on = 1'b0;
                end else if (line_meas_i > MEAS_NOM) begin
                    if (st_q.trim != '0) st_d.trim = st_q.trim - TRIM_W'(1);
                end else begin
                    if (st_q.trim != '1) st_d.trim = st_q.trim + TRIM_W'(1);
                end
            end
            cal_start = st_q.xtal_seen && (wr_cal_i || (st_q.lock_prev && !lock_i));
            if (cal_start) st_d.cal_on = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.xtal_seen <= 1'b0;
            st_q.cal_on    <= 1'b0;
            st_q.lock_prev <= 1'b0;
            st_q.trim      <= TRIM_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign trim_o = st_q.trim;

    // R2
    por_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (trim_o == TRIM_RST));
    // R3
    no_cal_before_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.xtal_seen && !por_i) |=> !st_q.cal_on);
    // R4
    trim_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cal_on && line_end_i && !por_i && line_meas_i > MEAS_NOM && trim_o != '0)
        |=> (trim_o == $past(trim_o) - TRIM_W'(1)));
    // R4
    cal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cal_on && line_end_i && line_meas_i == MEAS_NOM && !por_i && !cal_start)
        |=> (!st_q.cal_on && $stable(trim_o)));
endmodule

// File: rtl/lds_drive_gate.sv
module lds_drive_gate #(
    parameter int CNT_W      = 9,
    parameter int DUTY_START = 9,
    parameter int DUTY_END   = 238
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_i,
    input  logic             prot_i,
    input  logic             wr_cal_i,
    input  logic             run_en_i,
    input  logic [CNT_W-1:0] cnt_d_i,
    output logic             hdrv_o,
    output logic             por_flag_o,
    output logic             prot_flag_o
);
    localparam logic [CNT_W-1:0] D_LO = CNT_W'(DUTY_START);
    localparam logic [CNT_W-1:0] D_HI = CNT_W'(DUTY_END);

    typedef struct packed {
        logic             por_f;
        logic             prot_f;
        logic             run;
        logic             drv;
        logic [CNT_W-1:0] duty;
    } drv_st_t;

    drv_st_t st_q, st_d;
    logic    restart;

    always_comb begin
        st_d        = st_q;
        restart     = wr_cal_i & run_en_i;
        st_d.por_f  = por_i  | (st_q.por_f  & ~restart);
        st_d.prot_f = prot_i | (st_q.prot_f & ~restart);
        st_d.run    = run_en_i & ~st_d.por_f & ~st_d.prot_f;
        st_d.drv    = st_d.run & (cnt_d_i < st_q.duty);
        if (!st_d.run)
            st_d.duty = D_LO;
        else if (st_q.run && st_q.drv && (cnt_d_i == st_q.duty) && (st_q.duty < D_HI))
            st_d.duty = st_q.duty + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.por_f  <= 1'b1;
            st_q.prot_f <= 1'b0;
            st_q.run    <= 1'b0;
            st_q.drv    <= 1'b0;
            st_q.duty   <= D_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign hdrv_o      = st_q.drv;
    assign por_flag_o  = st_q.por_f;
    assign prot_flag_o = st_q.prot_f;

    // R6
    gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_flag_o || prot_flag_o) |-> !hdrv_o);
    // R6
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> !hdrv_o);
    // R7
    prot_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_i |=> prot_flag_o);
    // R8
    duty_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.duty >= D_LO) && (st_q.duty <= D_HI));
endmodule

// File: rtl/lds_loop_tc.sv
module lds_loop_tc
    import lds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       open_i,
    input  logic       noisy_i,
    input  logic       lock_i,
    output logic [1:0] tc_o
);
    typedef struct packed {
        loop_tc_e tc;
    } tc_st_t;

    tc_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (open_i)                             st_d.tc = TC_OPEN;
        else if (mode_i == 2'(MODE_SLOW))       st_d.tc = TC_SLOW;
        else if (mode_i == 2'(MODE_FAST))       st_d.tc = TC_FAST;
        else if (!lock_i && !noisy_i)           st_d.tc = TC_MED;
        else                                    st_d.tc = TC_SLOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.tc <= TC_OPEN;
        else        st_q    <= st_d;
    end

    assign tc_o = st_q.tc;

    // R9
    open_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |=> (tc_o == 2'(TC_OPEN)));
endmodule

// File: rtl/line_drive_supervisor.sv
module line_drive_supervisor #(
    parameter int LINE_CLKS  = 432,
    parameter int MEAS_W     = 10,
    parameter int TRIM_W     = 6,
    parameter int TRIM_POR   = 60,
    parameter int DUTY_START = 9,
    parameter int DUTY_END   = 238
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_i,
    input  logic              prot_trip_i,
    input  logic              lock_i,
    input  logic              wr_sub0_i,
    input  logic              wr_sub1_i,
    input  logic              run_en_i,
    input  logic              noisy_i,
    input  logic              loop_open_i,
    input  logic [1:0]        loop_mode_i,
    input  logic [MEAS_W-1:0] line_meas_i,
    output logic              hdrv_o,
    output logic              por_flag_o,
    output logic              prot_flag_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic [1:0]        loop_tc_o
);
    localparam int CNT_W = $clog2(LINE_CLKS);

    logic [CNT_W-1:0] cnt_d;
    logic             line_end;

    lds_line_timer #(.LINE_CLKS(LINE_CLKS), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .cnt_d_o(cnt_d), .line_end_o(line_end)
    );

    lds_osc_cal #(
        .LINE_CLKS(LINE_CLKS), .MEAS_W(MEAS_W), .TRIM_W(TRIM_W), .TRIM_POR(TRIM_POR)
    ) u_cal (
        .clk(clk), .rst_n(rst_n), .por_i(por_i), .wr_xtal_i(wr_sub0_i),
        .wr_cal_i(wr_sub1_i), .lock_i(lock_i), .line_end_i(line_end),
        .line_meas_i(line_meas_i), .trim_o(trim_o)
    );

    lds_drive_gate #(
        .CNT_W(CNT_W), .DUTY_START(DUTY_START), .DUTY_END(DUTY_END)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .por_i(por_i), .prot_i(prot_trip_i),
        .wr_cal_i(wr_sub1_i), .run_en_i(run_en_i), .cnt_d_i(cnt_d),
        .hdrv_o(hdrv_o), .por_flag_o(por_flag_o), .prot_flag_o(prot_flag_o)
    );

    lds_loop_tc u_tc (
        .clk(clk), .rst_n(rst_n), .mode_i(loop_mode_i), .open_i(loop_open_i),
        .noisy_i(noisy_i), .lock_i(lock_i), .tc_o(loop_tc_o)
    );
endmodule

// File: tb/sim_line_drive_supervisor.sv
`timescale 1ns/1ps
module sim_line_drive_supervisor;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       por_i = 0, prot_trip_i = 0, lock_i = 0;
    logic       wr_sub0_i = 0, wr_sub1_i = 0, run_en_i = 0;
    logic       noisy_i = 0, loop_open_i = 0;
    logic [1:0] loop_mode_i = 0;
    logic [9:0] line_meas_i;
    logic       hdrv_o, por_flag_o, prot_flag_o;
    logic [5:0] trim_o;
    logic [1:0] loop_tc_o;
    int         target = 40;

    always #10 clk = ~clk;

    assign line_meas_i = 10'(432 + int'(trim_o) - target);

    line_drive_supervisor u0 (.*);

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %0d exp %0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int mcnt, mtrim, mduty, mtc;
    bit mpor, mprot, mxtal, mcal, mlock, mrun, mdrv;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt = 0; mpor = 1; mprot = 0; mxtal = 0; mcal = 0; mtrim = 60;
            mlock = 0; mrun = 0; mduty = 9; mdrv = 0; mtc = 0;
        end else begin
            int ncnt, ntrim, nduty, ntc, meas;
            bit le, restart, npor, nprot, nxtal, ncal, nrun, ndrv;
            le = (mcnt == 431);
            ncnt = le ? 0 : mcnt + 1;
            meas = 432 + mtrim - target;
            restart = wr_sub1_i && run_en_i;
            npor = por_i || (mpor && !restart);
            nprot = prot_trip_i || (mprot && !restart);
            ntrim = mtrim; ncal = mcal; nxtal = mxtal;
            if (por_i) begin
                nxtal = 0; ncal = 0; ntrim = 60;
            end else begin
                nxtal = mxtal || wr_sub0_i;
                if (mcal && le) begin
                    if (meas == 432) ncal = 0;
                    else if (meas > 432) ntrim = (mtrim > 0) ? mtrim - 1 : 0;
                    else ntrim = (mtrim < 63) ? mtrim + 1 : 63;
                end
                if (mxtal && (wr_sub1_i || (mlock && !lock_i))) ncal = 1;
            end
            nrun = run_en_i && !npor && !nprot;
            ndrv = nrun && (ncnt < mduty);
            if (!nrun) nduty = 9;
            else if (mrun && mdrv && ncnt == mduty && mduty < 238) nduty = mduty + 1;
            else nduty = mduty;
            if (loop_open_i) ntc = 0;
            else if (loop_mode_i == 1) ntc = 1;
            else if (loop_mode_i == 2) ntc = 3;
            else if (!lock_i && !noisy_i) ntc = 2;
            else ntc = 1;
            mcnt = ncnt; mpor = npor; mprot = nprot; mxtal = nxtal; mcal = ncal;
            mtrim = ntrim; mlock = lock_i; mrun = nrun; mdrv = ndrv; mduty = nduty; mtc = ntc;
        end
    end

    // per-cycle comparison and pulse measurement
    int hcount = 0, last_w = 0, first_w = 0, period = 0, last_rise = -1;
    bit cap_first = 0, prev_h = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(hdrv_o == mdrv, "R8 R6 drive", hdrv_o, mdrv);
            chk(por_flag_o == mpor, "R2 R7 por flag", por_flag_o, mpor);
            chk(prot_flag_o == mprot, "R7 prot flag", prot_flag_o, mprot);
            chk(int'(trim_o) == mtrim, "R4 trim", trim_o, mtrim);
            chk(int'(loop_tc_o) == mtc, "R9 loop tc", loop_tc_o, mtc);
            if (hdrv_o) begin
                hcount++;
                if (!prev_h) begin
                    if (last_rise >= 0) period = cyc - last_rise;
                    last_rise = cyc;
                end
            end else if (hcount > 0) begin
                last_w = hcount;
                if (cap_first) begin first_w = hcount; cap_first = 0; end
                hcount = 0;
            end
            prev_h = hdrv_o;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1; @(negedge clk); s = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1;
        wait_cyc(2);
        // R2 reset state
        chk(por_flag_o == 1, "R2 por flag after reset", por_flag_o, 1);
        chk(hdrv_o == 0, "R2 drive after reset", hdrv_o, 0);
        chk(trim_o == 60, "R2 trim after reset", trim_o, 60);
        chk(loop_tc_o == 2, "R9 auto unlocked quiet", loop_tc_o, 2);
        // R3 write of second register without the first: no calibration
        target = 40;
        pulse(wr_sub1_i);
        wait_cyc(3 * 432);
        chk(trim_o == 60, "R3 no calibration without crystal write", trim_o, 60);
        chk(por_flag_o == 1, "R7 flag kept without run bit", por_flag_o, 1);
        // proper sequence
        pulse(wr_sub0_i);
        wait_cyc(100);
        run_en_i = 1;
        cap_first = 1;
        pulse(wr_sub1_i);
        chk(por_flag_o == 0, "R7 por flag cleared by restart", por_flag_o, 0);
        wait_cyc(864);
        chk(trim_o == 58, "R4 trim two steps down", trim_o, 58);
        wait_cyc(25 * 432);
        chk(trim_o == 40, "R4 trim stops on match", trim_o, 40);
        wait_cyc(210 * 432);
        chk(first_w == 9, "R8 first pulse width", first_w, 9);
        chk(last_w == 238, "R8 final pulse width", last_w, 238);
        chk(period == 432, "R1 line period", period, 432);
        // R9 modes
        loop_mode_i = 2; wait_cyc(2);
        chk(loop_tc_o == 3, "R9 forced fast", loop_tc_o, 3);
        loop_mode_i = 1; wait_cyc(2);
        chk(loop_tc_o == 1, "R9 forced slow", loop_tc_o, 1);
        loop_open_i = 1; wait_cyc(2);
        chk(loop_tc_o == 0, "R9 open loop", loop_tc_o, 0);
        loop_open_i = 0; loop_mode_i = 3; noisy_i = 1; wait_cyc(2);
        chk(loop_tc_o == 1, "R9 auto noisy", loop_tc_o, 1);
        noisy_i = 0; lock_i = 1; wait_cyc(2);
        chk(loop_tc_o == 1, "R9 auto locked", loop_tc_o, 1);
        // R6 standby
        run_en_i = 0; wait_cyc(2);
        hcount = 0;
        wait_cyc(432);
        chk(hcount == 0 && hdrv_o == 0, "R6 standby no drive", hcount, 0);
        cap_first = 1;
        wait_cyc(150);
        run_en_i = 1;
        wait_cyc(3 * 432);
        chk(first_w == 9, "R8 ramp restarts after standby", first_w, 9);
        // R5 loss of lock
        target = 45;
        lock_i = 0;
        wait_cyc(8 * 432);
        chk(trim_o == 45, "R5 recalibration after lock loss", trim_o, 45);
        // R7 protection trip
        pulse(prot_trip_i);
        chk(prot_flag_o == 1, "R7 prot latched", prot_flag_o, 1);
        hcount = 0;
        wait_cyc(432);
        chk(hcount == 0, "R6 no drive after trip", hcount, 0);
        prot_trip_i = 1; wr_sub1_i = 1; @(negedge clk); prot_trip_i = 0; wr_sub1_i = 0;
        chk(prot_flag_o == 1, "R7 trip wins over restart", prot_flag_o, 1);
        pulse(wr_sub1_i);
        chk(prot_flag_o == 0, "R7 prot cleared by restart", prot_flag_o, 0);
        wait_cyc(2 * 432);
        // R2 POR during run
        pulse(por_i);
        chk(por_flag_o == 1, "R2 por flag on por", por_flag_o, 1);
        chk(hdrv_o == 0, "R2 drive off on por", hdrv_o, 0);
        chk(trim_o == 60, "R2 trim high on por", trim_o, 60);
        wait_cyc(20);
        finish_run();
    end

    initial begin
        wait (cyc > 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired act %0d exp %0d", cyc, 190000);
            finish_run();
        end
    end
endmodule